// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the 32-bit execution hardware of a processor that runs under a microcoded controller. Every move of data inside it goes over one shared bus. Exactly one source puts a value on the bus in a cycle, and any number of destinations capture it at the next rising clock edge. The sources are the register file, the immediate extender, the ALU and memory read data. The destinations are the register file, the instruction register, the two ALU operand latches, the memory address register and the program counter. The program counter sits in the register file as one extra entry that is reached through its own select code.

A sequencer outside the block presents one wide horizontal control word per cycle, made of individual enables, load strobes and small select fields. The block gives the sequencer what it needs to branch: the opcode field of the instruction register, a flag that is high when operand latch A holds zero, and the memory busy flag passed straight through.

Memory is reached through plain strobes. A read or write strobe is raised while the control word asks for memory, and the address comes from the memory address register. There is no valid/ready stream at this edge. Back-pressure is the busy input: the sequencer repeats the same control word for as long as busy stays high, so a stalled access costs cycles but never loses data.

Top module: `sbus_datapath`

## Requirements
- R1: The bus carries the value of the one enabled source: register file read data (en_reg), extended immediate (en_imm), ALU result (en_alu) or mem_rdata (en_mem). When no source enable is high, the bus is 0.
- R2: Register select reg_sel chooses the register file entry to read or write. Code 0 selects IR[25:21], code 1 selects IR[20:16], code 2 selects IR[15:11], code 3 selects register 31, and codes 4 to 7 select the program counter.
- R3: When reg_wr is high, the bus value is stored at the rising edge into the entry picked by reg_sel. Register 0 is writable like any other register and reads back what was written.
- R4: ld_ir, ld_a, ld_b and ld_ma each capture the bus value at the rising edge into their register. A register whose strobe is low keeps its value.
- R5: The ALU result depends on alu_op. Code 0 gives A+B and code 1 gives A+4. Code 3 passes A through. Code 2 applies the function in IR[2:0]: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left by B[4:0], 6 logical shift right by B[4:0], 7 signed less-than.
- R6: The immediate depends on ext_sel. Code 0 is IR[15:0] sign-extended, code 1 is IR[15:0] zero-extended, code 2 is IR[25:0] sign-extended, and code 3 gives 0.
- R7: mem_addr always shows the memory address register. mem_rd follows en_mem and mem_we follows mem_wr. mem_wdata shows the bus, and busy mirrors mem_busy in the same cycle.
- R8: zero is high exactly when operand latch A holds 0.
- R9: opcode shows IR[31:26].
- R10: An active-low reset clears the instruction register, A, B, the memory address register, the program counter and all 32 registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register file entry select |
| en_reg | input | 1 | Register file drives the bus |
| en_imm | input | 1 | Immediate extender drives the bus |
| en_alu | input | 1 | ALU drives the bus |
| en_mem | input | 1 | Memory read data drives the bus; raises the read strobe |
| ld_ir | input | 1 | Load instruction register from the bus |
| ld_a | input | 1 | Load operand latch A |
| ld_b | input | 1 | Load operand latch B |
| ld_ma | input | 1 | Load memory address register |
| reg_wr | input | 1 | Write the bus into the selected register file entry |
| mem_wr | input | 1 | Memory write request |
| ext_sel | input | 2 | Immediate extension mode |
| alu_op | input | 2 | ALU operation select |
| mem_rdata | input | 32 | Memory read data |
| mem_busy | input | 1 | Memory access still in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory address, from the memory address register |
| mem_wdata | output | 32 | Memory write data, from the bus |
| bus | output | 32 | Current bus value |
| opcode | output | 6 | Instruction opcode field |
| zero | output | 1 | Operand latch A is zero |
| busy | output | 1 | Memory busy flag for the sequencer |

## Verification
Every internal register can only be seen through the bus, so a register that captured the wrong value shows up in the first later cycle that reads it back onto the bus. A wrong A latch also shows at once on zero, and a wrong instruction register shows at once on opcode. A wrong memory address register shows on mem_addr one cycle after its load. A field or select mismatch, such as reg_sel decoding the wrong IR field, stays hidden until a later read hits a register whose value differs from the intended one. For that reason the stimulus writes distinct values into every register it later reads.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [2:0] {
    SEL_RS1  = 3'd0,
    SEL_RS2  = 3'd1,
    SEL_RD   = 3'd2,
    SEL_LINK = 3'd3,
    SEL_PC   = 3'd4
  } rsel_e;

  typedef enum logic [1:0] {
    EXT_S16 = 2'd0,
    EXT_Z16 = 2'd1,
    EXT_S26 = 2'd2,
    EXT_NUL = 2'd3
  } ext_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_INC4 = 2'd1,
    ALU_FUNC = 2'd2,
    ALU_PASS = 2'd3
  } aluop_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_XOR = 3'd4,
    FN_SLL = 3'd5,
    FN_SRL = 3'd6,
    FN_SLT = 3'd7
  } func_e;

  // Instruction field positions; the sequencer decodes the opcode field.
  localparam int OPC_HI  = 31;
  localparam int OPC_LO  = 26;
  localparam int RS1_HI  = 25;
  localparam int RS1_LO  = 21;
  localparam int RS2_HI  = 20;
  localparam int RS2_LO  = 16;
  localparam int RD_HI   = 15;
  localparam int RD_LO   = 11;
  localparam int IMM_S   = 16;
  localparam int IMM_L   = 26;
  localparam int LINK_IX = 31;

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  // Entries 0..NREG-1 are general registers; entry NREG is the program counter.
  logic [W-1:0] ent [NREG+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= NREG; i++) ent[i] <= '0;
    end else if (we) begin
      ent[addr] <= wdata;
    end
  end

  assign rdata = ent[addr];

endmodule

// File: rtl/sbus_imm_ext.sv
module sbus_imm_ext
  import sbus_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] ir,
  input  logic [1:0]   mode,
  output logic [W-1:0] imm
);

  always_comb begin
    unique case (ext_e'(mode))
      EXT_S16: imm = {{(W-IMM_S){ir[IMM_S-1]}}, ir[IMM_S-1:0]};
      EXT_Z16: imm = {{(W-IMM_S){1'b0}}, ir[IMM_S-1:0]};
      EXT_S26: imm = {{(W-IMM_L){ir[IMM_L-1]}}, ir[IMM_L-1:0]};
      default: imm = '0;
    endcase
  end

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  input  logic [2:0]   func,
  output logic [W-1:0] y
);

  logic [W-1:0] fn_y;
  logic [SW-1:0] sh;

  assign sh = b[SW-1:0];

  always_comb begin
    unique case (func_e'(func))
      FN_ADD: fn_y = a + b;
      FN_SUB: fn_y = a - b;
      FN_AND: fn_y = a & b;
      FN_OR:  fn_y = a | b;
      FN_XOR: fn_y = a ^ b;
      FN_SLL: fn_y = a << sh;
      FN_SRL: fn_y = a >> sh;
      default: fn_y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
    endcase
  end

  always_comb begin
    unique case (aluop_e'(op))
      ALU_ADD:  y = a + b;
      ALU_INC4: y = a + W'(4);
      ALU_FUNC: y = fn_y;
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG + 1),
  localparam int OW  = OPC_HI - OPC_LO + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_sel,
  input  logic          en_reg,
  input  logic          en_imm,
  input  logic          en_alu,
  input  logic          en_mem,
  input  logic          ld_ir,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic          ld_ma,
  input  logic          reg_wr,
  input  logic          mem_wr,
  input  logic [1:0]    ext_sel,
  input  logic [1:0]    alu_op,
  input  logic [W-1:0]  mem_rdata,
  input  logic          mem_busy,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic [W-1:0]  bus,
  output logic [OW-1:0] opcode,
  output logic          zero,
  output logic          busy
);

  logic [W-1:0] ir_q, a_q, b_q, ma_q;
  logic [W-1:0] rf_rdata, imm_val, alu_y;
  logic [AW-1:0] rf_addr;

  // Register select decode
  always_comb begin
    unique case (reg_sel)
      SEL_RS1:  rf_addr = AW'(ir_q[RS1_HI:RS1_LO]);
      SEL_RS2:  rf_addr = AW'(ir_q[RS2_HI:RS2_LO]);
      SEL_RD:   rf_addr = AW'(ir_q[RD_HI:RD_LO]);
      SEL_LINK: rf_addr = AW'(LINK_IX);
      default:  rf_addr = AW'(NREG);
    endcase
  end

  sbus_regfile #(.W(W), .NREG(NREG)) i_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (rf_addr),
    .we    (reg_wr),
    .wdata (bus),
    .rdata (rf_rdata)
  );

  sbus_imm_ext #(.W(W)) i_ext (
    .ir   (ir_q),
    .mode (ext_sel),
    .imm  (imm_val)
  );

  sbus_alu #(.W(W)) i_alu (
    .a    (a_q),
    .b    (b_q),
    .op   (alu_op),
    .func (ir_q[2:0]),
    .y    (alu_y)
  );

  // Shared bus: AND-OR of gated sources, idle value zero
  always_comb begin
    bus = '0;
    bus |= {W{en_reg}} & rf_rdata;
    bus |= {W{en_imm}} & imm_val;
    bus |= {W{en_alu}} & alu_y;
    bus |= {W{en_mem}} & mem_rdata;
  end

  // Bus destinations
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ld_ir) ir_q <= bus;
      if (ld_a)  a_q  <= bus;
      if (ld_b)  b_q  <= bus;
      if (ld_ma) ma_q <= bus;
    end
  end

  assign mem_addr  = ma_q;
  assign mem_wdata = bus;
  assign mem_rd    = en_mem;
  assign mem_we    = mem_wr;
  assign busy      = mem_busy;
  assign opcode    = ir_q[OPC_HI:OPC_LO];
  assign zero      = (a_q == '0);

endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_reg,
  input logic         en_imm,
  input logic         en_alu,
  input logic         en_mem,
  input logic         ld_ir,
  input logic         ld_a,
  input logic         ld_ma,
  input logic [1:0]   ext_sel,
  input logic [W-1:0] bus,
  input logic [W-1:0] mem_addr,
  input logic [5:0]   opcode,
  input logic         zero
);

  p_single_driver_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_reg, en_imm, en_alu, en_mem}));

  p_idle_bus_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_reg || en_imm || en_alu || en_mem) |-> (bus == '0));

  p_ma_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ma |=> (mem_addr == $past(bus)));

  p_ma_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ma |=> $stable(mem_addr));

  p_sext16_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_imm && !en_reg && !en_alu && !en_mem && ext_sel == 2'd0)
      |-> (bus[W-1:15] == {(W-15){bus[15]}}));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> (zero == ($past(bus) == '0)));

  p_opcode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ir |=> (opcode == $past(bus[31:26])));

endmodule

bind sbus_datapath sbus_datapath_chk #(.W(W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_reg   (en_reg),
  .en_imm   (en_imm),
  .en_alu   (en_alu),
  .en_mem   (en_mem),
  .ld_ir    (ld_ir),
  .ld_a     (ld_a),
  .ld_ma    (ld_ma),
  .ext_sel  (ext_sel),
  .bus      (bus),
  .mem_addr (mem_addr),
  .opcode   (opcode),
  .zero     (zero)
);

// File: tb/test_sbus_datapath.sv
module test_sbus_datapath;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        en_reg = 0, en_imm = 0, en_alu = 0, en_mem = 0;
  logic        ld_ir = 0, ld_a = 0, ld_b = 0, ld_ma = 0, reg_wr = 0, mem_wr = 0;
  logic [1:0]  ext_sel = '0, alu_op = '0;
  logic [31:0] mem_rdata = '0;
  logic        mem_busy = 1'b0;
  logic        mem_rd, mem_we, zero, busy;
  logic [31:0] mem_addr, mem_wdata, bus;
  logic [5:0]  opcode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  sbus_datapath i_sbus_datapath (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel),
    .en_reg(en_reg), .en_imm(en_imm), .en_alu(en_alu), .en_mem(en_mem),
    .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma),
    .reg_wr(reg_wr), .mem_wr(mem_wr), .ext_sel(ext_sel), .alu_op(alu_op),
    .mem_rdata(mem_rdata), .mem_busy(mem_busy),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .bus(bus), .opcode(opcode), .zero(zero), .busy(busy)
  );

  // en = {reg,imm,alu,mem}; ld = {ir,a,b,ma,reg_wr,mem_wr}
  typedef struct packed {
    logic [2:0]  sel;
    logic [3:0]  en;
    logic [5:0]  ld;
    logic [1:0]  ext;
    logic [1:0]  op;
    logic [31:0] rdata;
    logic [31:0] exp;
  } vec_t;

  localparam logic [31:0] I1 = 32'h3022_8005; // opc 0C, rs1 1, rs2 2, rd 16, func 5
  localparam logic [31:0] I2 = 32'hFC07_0006; // opc 3F, rs1 0, rs2 7, rd 0, func 6
  localparam int NV = 18;

  localparam vec_t TBL [NV] = '{
    '{3'd0, 4'b0001, 6'b100000, 2'd0, 2'd0, I1,    I1},            // R1 R4 load IR
    '{3'd0, 4'b0100, 6'b000010, 2'd0, 2'd0, 32'h0, 32'hFFFF_8005}, // R6 sext16 -> r1
    '{3'd1, 4'b0100, 6'b000010, 2'd1, 2'd0, 32'h0, 32'h0000_8005}, // R6 zext16 -> r2
    '{3'd2, 4'b0100, 6'b000010, 2'd2, 2'd0, 32'h0, 32'h0022_8005}, // R6 sext26 -> r16
    '{3'd0, 4'b1000, 6'b010000, 2'd0, 2'd0, 32'h0, 32'hFFFF_8005}, // R2 A <- rs1
    '{3'd1, 4'b1000, 6'b001000, 2'd0, 2'd0, 32'h0, 32'h0000_8005}, // R2 B <- rs2
    '{3'd0, 4'b0010, 6'b000100, 2'd0, 2'd0, 32'h0, 32'h0000_000A}, // R5 add -> MA
    '{3'd0, 4'b0010, 6'b000000, 2'd0, 2'd1, 32'h0, 32'hFFFF_8009}, // R5 A+4
    '{3'd0, 4'b0010, 6'b000000, 2'd0, 2'd2, 32'h0, 32'hFFF0_00A0}, // R5 func sll
    '{3'd2, 4'b1000, 6'b000000, 2'd0, 2'd0, 32'h0, 32'h0022_8005}, // R2 R3 read rd
    '{3'd4, 4'b1000, 6'b000000, 2'd0, 2'd0, 32'h0, 32'h0},         // R10 PC reset
    '{3'd4, 4'b0010, 6'b000010, 2'd0, 2'd0, 32'h0, 32'h0000_000A}, // R3 PC <- A+B
    '{3'd4, 4'b1000, 6'b000000, 2'd0, 2'd0, 32'h0, 32'h0000_000A}, // R2 read PC
    '{3'd4, 4'b1000, 6'b010000, 2'd0, 2'd0, 32'h0, 32'h0000_000A}, // R4 A <- PC
    '{3'd3, 4'b0010, 6'b000010, 2'd0, 2'd3, 32'h0, 32'h0000_000A}, // R5 link <- A
    '{3'd3, 4'b1000, 6'b000000, 2'd0, 2'd0, 32'h0, 32'h0000_000A}, // R2 read r31
    '{3'd0, 4'b0000, 6'b000000, 2'd0, 2'd0, 32'h0, 32'h0},         // R1 idle bus
    '{3'd1, 4'b1000, 6'b000001, 2'd0, 2'd0, 32'h0, 32'h0000_8005}  // R7 store data
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {en_reg, en_imm, en_alu, en_mem} = '0;
    {ld_ir, ld_a, ld_b, ld_ma, reg_wr, mem_wr} = '0;
    reg_sel = '0; ext_sel = '0; alu_op = '0; mem_rdata = '0;
  endtask

  task automatic apply(input vec_t v);
    reg_sel = v.sel;
    {en_reg, en_imm, en_alu, en_mem} = v.en;
    {ld_ir, ld_a, ld_b, ld_ma, reg_wr, mem_wr} = v.ld;
    ext_sel = v.ext; alu_op = v.op; mem_rdata = v.rdata;
  endtask

  // Apply at falling edge, sample 5 ns later, commit at next rising edge.
  task automatic step(input vec_t v);
    @(negedge clk);
    apply(v);
    #5;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    #5;
    chk("R10 reset bus", bus, 32'h0);
    chk("R10 reset opcode", {26'h0, opcode}, 32'h0);
    chk("R10 reset mem_addr", mem_addr, 32'h0);
    chk("R8 reset zero", {31'h0, zero}, 32'h1);
    chk("R7 reset strobes", {30'h0, mem_rd, mem_we}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i]);
      chk($sformatf("R1 table step %0d bus", i), bus, TBL[i].exp);
    end
    chk("R7 write strobe", {31'h0, mem_we}, 32'h1);
    chk("R7 write data", mem_wdata, 32'h0000_8005);

    @(negedge clk); idle(); #1;
    chk("R9 opcode", {26'h0, opcode}, 32'h0000_000C);
    chk("R7 address from MA", mem_addr, 32'h0000_000A);
    chk("R8 zero low", {31'h0, zero}, 32'h0);

    // memory read strobe and busy mirror
    en_mem = 1; mem_rdata = 32'h1234_5678; mem_busy = 1; #1;
    chk("R7 read strobe", {31'h0, mem_rd}, 32'h1);
    chk("R7 busy mirror", {31'h0, busy}, 32'h1);
    chk("R1 mem drives bus", bus, 32'h1234_5678);
    mem_busy = 0; #1;
    chk("R7 busy low", {31'h0, busy}, 32'h0);

    // A loaded from an undriven bus -> zero
    step('{3'd0, 4'b0000, 6'b010000, 2'd0, 2'd0, 32'h0, 32'h0});
    @(negedge clk); idle(); #1;
    chk("R8 zero high", {31'h0, zero}, 32'h1);

    // MA holds when not loaded
    chk("R4 MA hold", mem_addr, 32'h0000_000A);

    // new instruction, register 0 write
    step('{3'd0, 4'b0001, 6'b100000, 2'd0, 2'd0, I2, 32'h0});
    step('{3'd0, 4'b0001, 6'b000010, 2'd0, 2'd0, 32'hDEAD_BEEF, 32'h0});
    step('{3'd0, 4'b1000, 6'b010000, 2'd0, 2'd0, 32'h0, 32'h0});
    chk("R3 reg0 readback", bus, 32'hDEAD_BEEF);
    chk("R9 new opcode", {26'h0, opcode}, 32'h0000_003F);
    step('{3'd1, 4'b1000, 6'b000000, 2'd0, 2'd0, 32'h0, 32'h0});
    chk("R10 r7 untouched", bus, 32'h0);
    step('{3'd0, 4'b0100, 6'b001000, 2'd1, 2'd0, 32'h0, 32'h0});
    chk("R6 zext imm", bus, 32'h0000_0006);
    step('{3'd0, 4'b0010, 6'b000000, 2'd0, 2'd2, 32'h0, 32'h0});
    chk("R5 func srl", bus, 32'h037A_B6FB);
    step('{3'd0, 4'b0100, 6'b000000, 2'd3, 2'd0, 32'h0, 32'h0});
    chk("R6 null mode", bus, 32'h0);

    // reset in the middle of a run
    do_reset();
    step('{3'd0, 4'b1000, 6'b000000, 2'd0, 2'd0, 32'h0, 32'h0});
    chk("R10 reg0 cleared", bus, 32'h0);
    chk("R10 opcode cleared", {26'h0, opcode}, 32'h0);
    chk("R10 MA cleared", mem_addr, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule